// File: doc/BRIEF.md
# Matrix Performance Event Selector

This block sits between a core's microarchitectural event sources and a bank of performance counters. It supplies one increment pulse per counter per cycle. Each counter carries an event-type number. Most type numbers name an ordinary architected event, and that event's pulse line is forwarded to the counter. A window of type numbers starting at 0xD8 is reserved for two-level event selection.

Three 64-bit selection words are held in the block. Each word is divided into eight 8-bit group fields, and each field stores an event code. A windowed type number names a word and a group. The code stored in that group's field then chooses one line out of that group's bank of event pulses. Every counter that names the same word and group counts the same chosen event, so one programmed code is shared by all of them.

Software sets the selection words through a small address-decoded register port. The top bit of each word gates all matrix events drawn from it. All counter increments leave the block through registers, one cycle after the inputs that cause them.

Top module: `matrix_event_sel`

## Requirements
- R1: After synchronous reset, all three selection words read back as zero and every counter increment output is zero.
- R2: A write with the port address set to 0, 1 or 2 replaces the full 64-bit word at that index. A read returns the word at the address presented in the previous cycle.
- R3: The port address 3 always reads as zero, and a write to it changes none of the three words.
- R4: A type number outside 0xD8..0xEF makes the counter's output equal to arch_evt_i[type], one cycle later.
- R5: A type number 0xD8 + 8*r + g (r in 0..2, g in 0..6) makes the counter's output equal to mtx_evt_i[(8*r+g)*256 + c] one cycle later. Here c is bits [8g+7:8g] of word r, and bit 63 of word r must be set.
- R6: When bit 63 of word r is clear, every counter whose type number names word r outputs zero, whatever the codes and the event pulses.
- R7: For group 7, only the seven bits [62:56] of word r form the code. The selected line is mtx_evt_i[(8*r+7)*256 + c7], and lines 128..255 of group 7's bank never count.
- R8: Counters that carry the same type number in a cycle produce the same increment value.
- R9: A new word value is used for events presented from the cycle after the write edge. Events presented in the cycle of the write still use the old value. Each increment is a single-cycle copy of the input pulse.
- R10: For a type number inside the window, the arch_evt_i line with the same index has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the selection words |
| cfg_addr | input | 2 | Word index for reads and writes (0..2 valid) |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Registered read data for the previous cycle's address |
| ctr_type_i | input | 32 | Event-type number for each counter, 8 bits per counter, counter 0 in the low bits |
| arch_evt_i | input | 256 | Architected event pulses, indexed by type number |
| mtx_evt_i | input | 6144 | Matrix event pulses, 256 lines per (word, group) bank, bank index 8*r+g |
| ctr_inc_o | output | 4 | Registered increment pulse for each counter |

## Verification
Counter increments and read data are both due exactly one clock edge after the inputs that produce them. The bench therefore changes inputs on a falling edge and compares outputs on the next falling edge. A write takes one edge to land. The bench moves its own copy of the words forward only after that edge, so a pulse presented during the write cycle is judged against the old code, and the pulse in the following cycle is judged against the new one. Sweeps over all 256 type numbers and all 24 word/group slots compute each expected bit from the field arithmetic in the requirements.

// File: rtl/mes_pkg.sv
package mes_pkg;
  localparam int DEF_REGIONS = 3;
  localparam int DEF_GROUPS  = 8;
  localparam int DEF_CODE_W  = 8;
  localparam int DEF_TYPE_W  = 8;
  localparam int DEF_BASE    = 216;  // first windowed type number
  localparam int DEF_CTRS    = 4;
  localparam int DEF_ADDR_W  = 2;
endpackage

// File: rtl/mes_region_bank.sv
// Selection word storage with registered read-back.
module mes_region_bank #(
  parameter int NUM_REGIONS = 3,
  parameter int REG_W       = 64,
  parameter int ADDR_W      = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [REG_W-1:0]             wdata,
  output logic [REG_W-1:0]             rdata,
  output logic [NUM_REGIONS*REG_W-1:0] words_o
);
  logic [REG_W-1:0] word_q [NUM_REGIONS];
  logic [REG_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGIONS; r++) word_q[r] <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NUM_REGIONS; r++)
        if (addr == ADDR_W'(r)) word_q[r] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      for (int r = 0; r < NUM_REGIONS; r++)
        if (addr == ADDR_W'(r)) rdata_q <= word_q[r];
    end
  end

  assign rdata = rdata_q;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_flat
    assign words_o[r*REG_W +: REG_W] = word_q[r];
  end
endmodule

// File: rtl/mes_group_sel.sv
// Per-group code lookup for one selection word.
module mes_group_sel #(
  parameter int NUM_GROUPS = 8,
  parameter int CODE_W     = 8,
  localparam int REG_W     = NUM_GROUPS * CODE_W,
  localparam int EVT_N     = 1 << CODE_W
) (
  input  logic [REG_W-1:0]            word_i,
  input  logic [NUM_GROUPS*EVT_N-1:0] evt_i,
  output logic [NUM_GROUPS-1:0]       hit_o
);
  logic enable;
  assign enable = word_i[REG_W-1];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [CODE_W-1:0] idx;
    logic [EVT_N-1:0]  bank;
    if (g == NUM_GROUPS - 1) begin : g_top
      // top field shares its msb with the enable bit
      assign idx = {1'b0, word_i[g*CODE_W +: CODE_W-1]};
    end else begin : g_full
      assign idx = word_i[g*CODE_W +: CODE_W];
    end
    assign bank     = evt_i[g*EVT_N +: EVT_N];
    assign hit_o[g] = enable & bank[idx];
  end
endmodule

// File: rtl/mes_ctr_route.sv
// Type decode and registered increment for one counter.
module mes_ctr_route #(
  parameter int TYPE_W   = 8,
  parameter int SLOTS    = 24,
  parameter int MTX_BASE = 216,
  localparam int ARCH_N  = 1 << TYPE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [ARCH_N-1:0] arch_i,
  input  logic [SLOTS-1:0]  slot_hit_i,
  output logic              inc_o
);
  logic in_win;
  logic mtx_hit;
  logic inc_q;

  always_comb begin
    in_win  = 1'b0;
    mtx_hit = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (type_i == TYPE_W'(MTX_BASE + s)) begin
        in_win  = 1'b1;
        mtx_hit = slot_hit_i[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) inc_q <= 1'b0;
    else     inc_q <= in_win ? mtx_hit : arch_i[type_i];
  end

  assign inc_o = inc_q;
endmodule

// File: rtl/matrix_event_sel.sv
module matrix_event_sel #(
  parameter int NUM_CTRS    = mes_pkg::DEF_CTRS,
  parameter int NUM_REGIONS = mes_pkg::DEF_REGIONS,
  parameter int NUM_GROUPS  = mes_pkg::DEF_GROUPS,
  parameter int CODE_W      = mes_pkg::DEF_CODE_W,
  parameter int TYPE_W      = mes_pkg::DEF_TYPE_W,
  parameter int MTX_BASE    = mes_pkg::DEF_BASE,
  parameter int ADDR_W      = mes_pkg::DEF_ADDR_W,
  localparam int REG_W      = NUM_GROUPS * CODE_W,
  localparam int EVT_N      = 1 << CODE_W,
  localparam int SLOTS      = NUM_REGIONS * NUM_GROUPS,
  localparam int ARCH_N     = 1 << TYPE_W,
  localparam int MTX_W      = SLOTS * EVT_N
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr_en,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [REG_W-1:0]           cfg_rdata,
  input  logic [NUM_CTRS*TYPE_W-1:0] ctr_type_i,
  input  logic [ARCH_N-1:0]          arch_evt_i,
  input  logic [MTX_W-1:0]           mtx_evt_i,
  output logic [NUM_CTRS-1:0]        ctr_inc_o
);
  logic [NUM_REGIONS*REG_W-1:0] region_words;
  logic [SLOTS-1:0]             slot_hit;

  mes_region_bank #(
    .NUM_REGIONS(NUM_REGIONS), .REG_W(REG_W), .ADDR_W(ADDR_W)
  ) i_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .words_o(region_words)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    mes_group_sel #(.NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W)) i_sel (
      .word_i(region_words[r*REG_W +: REG_W]),
      .evt_i (mtx_evt_i[r*NUM_GROUPS*EVT_N +: NUM_GROUPS*EVT_N]),
      .hit_o (slot_hit[r*NUM_GROUPS +: NUM_GROUPS])
    );
  end

  for (genvar k = 0; k < NUM_CTRS; k++) begin : g_ctr
    mes_ctr_route #(.TYPE_W(TYPE_W), .SLOTS(SLOTS), .MTX_BASE(MTX_BASE)) i_route (
      .clk(clk), .rst(rst),
      .type_i(ctr_type_i[k*TYPE_W +: TYPE_W]),
      .arch_i(arch_evt_i),
      .slot_hit_i(slot_hit),
      .inc_o(ctr_inc_o[k])
    );
  end
endmodule

// File: rtl/mes_chk.sv
module mes_chk #(
  parameter int NUM_CTRS    = 4,
  parameter int NUM_REGIONS = 3,
  parameter int NUM_GROUPS  = 8,
  parameter int REG_W       = 64,
  parameter int TYPE_W      = 8,
  parameter int MTX_BASE    = 216,
  parameter int ADDR_W      = 2,
  localparam int ARCH_N     = 1 << TYPE_W
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         cfg_wr_en,
  input logic [ADDR_W-1:0]            cfg_addr,
  input logic [REG_W-1:0]             cfg_wdata,
  input logic [REG_W-1:0]             cfg_rdata,
  input logic [NUM_CTRS*TYPE_W-1:0]   ctr_type_i,
  input logic [ARCH_N-1:0]            arch_evt_i,
  input logic [NUM_CTRS-1:0]          ctr_inc_o,
  input logic [NUM_REGIONS*REG_W-1:0] words
);
  // R1: outputs are zero on the edge after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (ctr_inc_o == '0) && (cfg_rdata == '0));

  // R3: an address beyond the last word reads zero
  a_r3_read_unmapped: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(cfg_addr) >= ADDR_W'(NUM_REGIONS)) |-> cfg_rdata == '0);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_wr
    // R2: a write lands in the addressed word
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(cfg_wr_en) && ($past(cfg_addr) == ADDR_W'(r))
      |-> words[r*REG_W +: REG_W] == $past(cfg_wdata));
  end

  for (genvar k = 0; k < NUM_CTRS; k++) begin : g_ctr
    // R4: architected pass-through below the window
    a_r4_arch_pass: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && ($past(ctr_type_i[k*TYPE_W +: TYPE_W]) < TYPE_W'(MTX_BASE))
      |-> ctr_inc_o[k] == $past(arch_evt_i[ctr_type_i[k*TYPE_W +: TYPE_W]]));

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_dis
      // R6: a disabled word yields no counts
      a_r6_disabled_word: assert property (@(posedge clk) disable iff (rst)
        !$past(rst)
        && ($past(ctr_type_i[k*TYPE_W +: TYPE_W]) == TYPE_W'(MTX_BASE + r*NUM_GROUPS))
        && !$past(words[r*REG_W + REG_W - 1])
        |-> !ctr_inc_o[k]);
    end

    if (k > 0) begin : g_share
      // R8: equal type numbers give equal increments
      a_r8_shared_slot: assert property (@(posedge clk) disable iff (rst)
        !$past(rst)
        && ($past(ctr_type_i[k*TYPE_W +: TYPE_W]) == $past(ctr_type_i[0 +: TYPE_W]))
        |-> ctr_inc_o[k] == ctr_inc_o[0]);
    end
  end
endmodule

bind matrix_event_sel mes_chk #(
  .NUM_CTRS(NUM_CTRS), .NUM_REGIONS(NUM_REGIONS), .NUM_GROUPS(NUM_GROUPS),
  .REG_W(REG_W), .TYPE_W(TYPE_W), .MTX_BASE(MTX_BASE), .ADDR_W(ADDR_W)
) u_mes_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctr_type_i(ctr_type_i),
  .arch_evt_i(arch_evt_i), .ctr_inc_o(ctr_inc_o), .words(region_words)
);

// File: tb/test_matrix_event_sel.sv
module test_matrix_event_sel;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NR = 3, NG = 8, NC = 4, TW = 8, EVN = 256;
  localparam int MTXW = NR * NG * EVN;
  localparam int BASE = 216;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_wr_en = 1'b0;
  logic [1:0]      cfg_addr = '0;
  logic [63:0]     cfg_wdata = '0;
  logic [63:0]     cfg_rdata;
  logic [7:0]      typ [NC];
  logic [NC*TW-1:0] ctr_type;
  logic [255:0]    arch = '0;
  logic [MTXW-1:0] mtx = '0;
  logic [NC-1:0]   inc;

  logic [63:0] shadow [NR];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  always_comb for (int k = 0; k < NC; k++) ctr_type[k*TW +: TW] = typ[k];

  matrix_event_sel i_matrix_event_sel (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctr_type_i(ctr_type),
    .arch_evt_i(arch), .mtx_evt_i(mtx), .ctr_inc_o(inc)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected increment from the requirement arithmetic (R4..R7, R10)
  function automatic logic model(logic [7:0] t);
    int off, r, g;
    logic [63:0] w;
    logic [7:0] c;
    if (t < BASE || t > BASE + NR*NG - 1) return arch[t];
    off = t - BASE; r = off / NG; g = off % NG;
    w = shadow[r];
    if (!w[63]) return 1'b0;
    c = (g == NG-1) ? {1'b0, w[62:56]} : w[g*8 +: 8];
    return mtx[(r*NG + g)*EVN + c];
  endfunction

  task automatic run_and_check(string req);
    logic [NC-1:0] exp;
    for (int k = 0; k < NC; k++) exp[k] = model(typ[k]);
    step();
    chk(req, 64'(inc), 64'(exp));
  endtask

  task automatic wr(logic [1:0] a, logic [63:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr_en = 1'b0;
    if (a < NR) shadow[a] = d;
  endtask

  task automatic rd(logic [1:0] a, string req);
    cfg_addr = a;
    step();
    chk(req, cfg_rdata, (a < NR) ? shadow[a] : 64'h0);
  endtask

  function automatic logic [63:0] prog_word(int r, bit en);
    logic [63:0] w;
    for (int g = 0; g < NG; g++) w[g*8 +: 8] = 8'(((r*NG + g)*29 + 3) & 255);
    w[63] = en;
    return w;
  endfunction

  initial begin
    for (int r = 0; r < NR; r++) shadow[r] = '0;
    for (int k = 0; k < NC; k++) typ[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 inc", 64'(inc), 64'h0);
    for (int r = 0; r < NR; r++) rd(2'(r), "R1 read");

    // R2/R3: write and read back, unmapped address
    for (int r = 0; r < NR; r++) wr(2'(r), 64'hA5C3_0F1E_2D3C_4B5A ^ (64'(r+1) * 64'h0101_0000_0300_0007));
    for (int r = 0; r < NR; r++) rd(2'(r), "R2 readback");
    wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd3, "R3 unmapped read");
    for (int r = 0; r < NR; r++) rd(2'(r), "R3 words untouched");
    for (int r = 0; r < NR; r++) wr(2'(r), 64'h0);

    // R4/R6/R10: sweep all types, words disabled, matrix lines all high
    mtx = '1;
    for (int t = 0; t < 256; t++) begin
      for (int i = 0; i < 256; i++) arch[i] = (((i*7 + t*3) % 5) < 2);
      for (int k = 0; k < NC; k++) typ[k] = 8'((t + 61*k) & 255);
      run_and_check("R4/R6/R10 sweep disabled");
    end

    // R5/R8/R10: program all words, one-hot pulse per slot
    for (int r = 0; r < NR; r++) wr(2'(r), prog_word(r, 1'b1));
    arch = '1;
    for (int r = 0; r < NR; r++) begin
      for (int g = 0; g < NG; g++) begin
        logic [7:0] c;
        int s;
        s = r*NG + g;
        c = (g == NG-1) ? {1'b0, shadow[r][62:56]} : shadow[r][g*8 +: 8];
        typ[0] = 8'(BASE + s); typ[1] = 8'(BASE + s);
        typ[2] = 8'(BASE + (s + 1) % (NR*NG)); typ[3] = 8'h10;
        mtx = '0; mtx[s*EVN + c] = 1'b1;
        run_and_check("R5/R8 slot hit");
        chk("R5 selected line counts", 64'(inc[0]), 64'h1);
        chk("R8 shared slot", 64'(inc[1]), 64'(inc[0]));
        mtx = '0; mtx[s*EVN + (c ^ 8'h01)] = 1'b1;
        run_and_check("R5 neighbour line");
        chk("R5 neighbour line silent", 64'(inc[0]), 64'h0);
      end
    end

    // R7: group 7 ignores its upper half
    for (int r = 0; r < NR; r++) begin
      int s;
      logic [6:0] c7;
      s = r*NG + 7; c7 = shadow[r][62:56];
      for (int k = 0; k < NC; k++) typ[k] = 8'(BASE + s);
      mtx = '0; mtx[s*EVN + 128 + c7] = 1'b1;
      run_and_check("R7 upper half");
      chk("R7 upper half silent", 64'(inc[0]), 64'h0);
      mtx = '0; mtx[s*EVN + c7] = 1'b1;
      run_and_check("R7 seven-bit code");
    end

    // R6: codes kept, enable cleared on word 1
    wr(2'd1, prog_word(1, 1'b0));
    for (int g = 0; g < NG; g++) begin
      for (int k = 0; k < NC; k++) typ[k] = 8'(BASE + NG + g);
      mtx = '1;
      run_and_check("R6 enable clear");
    end
    wr(2'd1, prog_word(1, 1'b1));

    // sweep all types again with words enabled and patterned lines
    for (int t = 0; t < 256; t++) begin
      for (int i = 0; i < 256; i++) arch[i] = ((i + t) % 3 == 0);
      for (int i = 0; i < MTXW; i++) mtx[i] = ((i*13 + t) % 3 == 0);
      for (int k = 0; k < NC; k++) typ[k] = 8'((t + 37*k) & 255);
      run_and_check("R4/R5/R10 sweep enabled");
    end

    // R9: write timing and one-cycle pulses
    begin
      logic [63:0] nw;
      logic [7:0] cold, cnew;
      cold = shadow[0][7:0]; cnew = cold ^ 8'h5A;
      nw = shadow[0]; nw[7:0] = cnew;
      for (int k = 0; k < NC; k++) typ[k] = 8'(BASE);
      mtx = '0; mtx[cnew] = 1'b1;
      cfg_wr_en = 1'b1; cfg_addr = 2'd0; cfg_wdata = nw;
      step();
      cfg_wr_en = 1'b0;
      chk("R9 old code in write cycle", 64'(inc[0]), 64'h0);
      shadow[0] = nw;
      step();
      chk("R9 new code next cycle", 64'(inc[0]), 64'h1);
      mtx = '0;
      step();
      chk("R9 single-cycle pulse", 64'(inc[0]), 64'h0);
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule